// File: doc/BRIEF.md
# Subtractive GCD Processor

This block computes the greatest common divisor of two unsigned operands. It is built as a small controller driving a datapath. It sits idle until its start input is seen high. It then captures both operands into working registers and repeatedly subtracts the smaller register from the larger, one subtraction per clock. When the two registers match, the common value is written to a result register, and a done flag pulses for one cycle.

If either operand is zero, the loop is skipped and the other operand is returned. Because of this, no input pair can make the block run forever. After a result has been produced, the controller waits for start to go low before it accepts a new pair. A start held high therefore never triggers a second run. The operand width is a parameter.

Top module: `gcd_engine`

## Requirements
- R1: After a synchronous reset, `result` is 0 and `done` is 0.
- R2: When `start` is high at a clock edge while the block is idle, `opa` and `opb` are captured at that edge, and a computation begins.
- R3: For two nonzero operands, `result` becomes their greatest common divisor (12 and 8 give 4; 13 and 5 give 1).
- R4: If exactly one operand is zero, `result` becomes the other operand. If both are zero, `result` becomes 0. In both cases the result arrives two edges after the capture edge is counted as the first.
- R5: Each iteration cycle replaces the larger working register with the difference of the larger minus the smaller. The result therefore appears exactly k+2 clock edges after `start` is first sampled, where k is the number of subtractions the operand pair needs.
- R6: `done` is high for exactly one cycle, in the cycle in which `result` first shows the new value.
- R7: `result` holds its value whenever `done` is low. Changing `opa` or `opb` after the capture edge has no effect on the result.
- R8: After completion, while `start` stays high, no new computation starts: `done` stays low and `result` is unchanged. Only after `start` has been seen low does the block return to idle.
- R9: The operand and result width is set by parameter `WIDTH` (default 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation; must return low before the next one |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| result | output | WIDTH | Registered greatest common divisor |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The block's timing is fixed by its operands. The capture edge is followed by one edge per subtraction and one final edge that writes the result. The result and `done` are therefore due k+2 edges after `start` is raised, where the bench derives k from its own model of the subtraction loop. The bench counts edges from raising `start` and samples the outputs at each following falling edge. It requires `done` to appear at exactly the predicted count, with `result` unchanged at every earlier sample. It checks the cycle after `done`, and any cycles in which `start` is held high, for a silent `done` and a stable `result`.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_HOLD = 2'd2
  } gcd_state_e;

  // Control bundle from controller to datapath.
  typedef struct packed {
    logic ld_x;       // load working register A
    logic ld_y;       // load working register B
    logic x_from_in;  // 1: A takes operand, 0: A takes A-B
    logic y_from_in;  // 1: B takes operand, 0: B takes B-A
    logic ld_d;       // load result register
    logic d_from_y;   // 1: result takes B, 0: result takes A
  } gcd_ctl_t;

  // Status bundle from datapath to controller.
  typedef struct packed {
    logic x_lt_y;
    logic x_ne_y;
    logic x_zero;
    logic y_zero;
  } gcd_sts_t;

endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  gcd_sts_t sts,
  output gcd_ctl_t ctl,
  output logic     done
);

  gcd_state_e st_q, st_d;
  logic       done_q;

  always_comb begin
    st_d = st_q;
    ctl  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ctl.ld_x      = 1'b1;
          ctl.ld_y      = 1'b1;
          ctl.x_from_in = 1'b1;
          ctl.y_from_in = 1'b1;
          st_d          = ST_STEP;
        end
      end
      ST_STEP: begin
        if (sts.x_zero) begin
          ctl.ld_d     = 1'b1;
          ctl.d_from_y = 1'b1;
          st_d         = ST_HOLD;
        end else if (sts.y_zero || !sts.x_ne_y) begin
          ctl.ld_d = 1'b1;
          st_d     = ST_HOLD;
        end else if (sts.x_lt_y) begin
          ctl.ld_y = 1'b1;
        end else begin
          ctl.ld_x = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!start) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= ctl.ld_d;
    end
  end

  assign done = done_q;

  // R6: the done flag never lasts two cycles
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R8: while start stays high after completion, nothing is loaded
  p_hold_noload_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && start) |=> (st_q == ST_HOLD && !ctl.ld_x && !ctl.ld_y));

endmodule

// File: rtl/gcd_dpath.sv
module gcd_dpath
  import gcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  gcd_ctl_t         ctl,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output gcd_sts_t         sts,
  output logic [WIDTH-1:0] result
);

  logic [WIDTH-1:0] x_q, y_q, d_q;
  logic [WIDTH-1:0] x_minus_y, y_minus_x;
  logic [WIDTH-1:0] x_nxt, y_nxt, d_nxt;

  // Two dedicated subtractors
  assign x_minus_y = x_q - y_q;
  assign y_minus_x = y_q - x_q;

  // Comparators and zero detectors
  assign sts.x_lt_y = (x_q < y_q);
  assign sts.x_ne_y = (x_q != y_q);
  assign sts.x_zero = (x_q == '0);
  assign sts.y_zero = (y_q == '0);

  // Input multiplexers
  assign x_nxt = ctl.x_from_in ? opa : x_minus_y;
  assign y_nxt = ctl.y_from_in ? opb : y_minus_x;
  assign d_nxt = ctl.d_from_y  ? y_q : x_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
      d_q <= '0;
    end else begin
      if (ctl.ld_x) x_q <= x_nxt;
      if (ctl.ld_y) y_q <= y_nxt;
      if (ctl.ld_d) d_q <= d_nxt;
    end
  end

  assign result = d_q;

  // R5: an iteration on B strictly shrinks B, and one on A strictly shrinks A
  p_shrink_y_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl.ld_y && !ctl.y_from_in) |=> (y_q < $past(y_q)));
  p_shrink_x_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl.ld_x && !ctl.x_from_in) |=> (x_q < $past(x_q)));

  // R4: a result is never taken while both registers are nonzero and unequal
  p_finish_ok_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.ld_d |-> (sts.x_zero || sts.y_zero || !sts.x_ne_y));

endmodule

// File: rtl/gcd_engine.sv
module gcd_engine
  import gcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] result,
  output logic             done
);

  gcd_ctl_t ctl;
  gcd_sts_t sts;

  gcd_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .sts   (sts),
    .ctl   (ctl),
    .done  (done)
  );

  gcd_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .opa    (opa),
    .opb    (opb),
    .sts    (sts),
    .result (result)
  );

  // R7: the result moves only together with the done flag
  p_result_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R1: reset clears the outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!done && result == '0));

endmodule

// File: tb/sim_gcd_engine.sv
module sim_gcd_engine;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [W-1:0] result;
  logic         done;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gcd_engine #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .opa(opa), .opb(opb), .result(result), .done(done)
  );

  function automatic int ref_gcd(int a, int b);
    if (a == 0) return b;
    if (b == 0) return a;
    while (a != b) begin
      if (a < b) b = b - a; else a = a - b;
    end
    return a;
  endfunction

  function automatic int ref_steps(int a, int b);
    int k = 0;
    if (a == 0 || b == 0) return 0;
    while (a != b) begin
      if (a < b) b = b - a; else a = a - b;
      k++;
    end
    return k;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int a, input int b, input bit garble, input int hold);
    int cyc = 0;
    bit got = 0;
    bit early = 0;
    logic [W-1:0] prev = result;
    int exp_cyc = ref_steps(a, b) + 2;
    opa   = W'(a);
    opb   = W'(b);
    start = 1'b1;
    while (!got && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) got = 1;
      else if (result != prev) early = 1;
      if (garble) begin
        opa = W'($urandom_range(255, 0));
        opb = W'($urandom_range(255, 0));
      end
    end
    // R7: no change on result before done
    check(!early, "R7", int'(result), int'(prev));
    // R6: done appears
    check(got, "R6", int'(got), 1);
    // R3/R4: value
    if (a == 0 || b == 0)
      check(int'(result) == ref_gcd(a, b), "R4", int'(result), ref_gcd(a, b));
    else
      check(int'(result) == ref_gcd(a, b), "R3", int'(result), ref_gcd(a, b));
    // R5: exact latency
    check(cyc == exp_cyc, "R5", cyc, exp_cyc);
    prev = result;
    for (int i = 0; i < hold + 1; i++) begin
      opa = W'($urandom_range(255, 1));
      opb = W'($urandom_range(255, 1));
      @(posedge clk);
      @(negedge clk);
      // R6 single pulse, R8 no restart while start high
      check(!done, (i == 0) ? "R6" : "R8", int'(done), 0);
      check(result == prev, "R8", int'(result), int'(prev));
    end
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!done && result == prev, "R8", int'(result), int'(prev));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(result == '0, "R1", int'(result), 0);
    check(done == 1'b0, "R1", int'(done), 0);
    // R2/R3 directed
    run(12, 8, 0, 0);
    run(13, 5, 0, 0);
    run(8, 12, 0, 2);
    run(7, 7, 0, 0);
    // R4 zero operands
    run(0, 9, 0, 0);
    run(9, 0, 0, 0);
    run(0, 0, 0, 0);
    // R5 long run, R7 garbled inputs
    run(255, 1, 1, 0);
    run(1, 255, 1, 1);
    run(255, 255, 0, 0);
    // R9: full-width operands; random mix
    for (int n = 0; n < 40; n++) begin
      run(int'($urandom_range(255, 1)), int'($urandom_range(255, 1)),
          n[0], n % 3);
    end
    finished = 1'b1;
  end

  initial begin
    int limit = 150000;
    for (int c = 0; c < limit && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule